// File: doc/BRIEF.md
# Watchdog Timer with Lockable System Options

This block supervises software with a free-running watchdog. It also holds a
small options byte that chooses whether the watchdog runs, how long it waits,
and whether the processor may enter stop mode. Out of reset the watchdog is
already running with its long period. Software gets exactly one chance to
change the options: the first register write after reset loads them and sets
a lock. Every later write is ignored until the next reset.

While enabled, the watchdog counts bus clock cycles from its last clear.
Software clears it by pulsing a service strobe. If the count reaches the
selected period first, the block raises a one-cycle timeout reset request. A
separate input reports that the processor attempted to enter stop mode. If
stop mode has not been enabled, that attempt produces an illegal-operation
reset request on its own output, so the reset source can be told apart.

All pins are plain control and status signals. None of them carries a data
stream, so there is no valid/ready handshake and no back-pressure. A write is
taken on any clock edge where the write enable is high.

Top module: `sys_watchdog`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `cfg_rdata` reads 0xD3: bit 7 is enable = 1, bit 6 is long-period select = 1, bit 5 is stop-enable = 0, and bits 4:0 are 10011. Both reset-request outputs are low.
- R2: Bits 4:0 of `cfg_rdata` always read 10011. Bits 7:5 always show the options currently in force (enable, period select, stop-enable).
- R3: The first edge with `cfg_we` high after reset copies `opt_wdata[2:0]` into option bits 7:5, whatever the value. Every later write leaves the options unchanged until reset.
- R4: With enable = 1, `rst_wdog` is high for exactly the one cycle that follows the T-th rising edge after the edge that last cleared the counter. T is 2**LONG_EXP when select = 1 and 2**SHORT_EXP when select = 0 (defaults 262144 and 8192).
- R5: A service strobe sampled at an edge clears the counter, and `rst_wdog` stays low after that edge, even at the terminal count.
- R6: With enable = 0, the counter stays at zero and `rst_wdog` never goes high.
- R7: If the first write shortens the period while the count already exceeds the new terminal value, `rst_wdog` pulses after the next edge.
- R8: For every edge at which `stop_try` is high while stop-enable is 0, `rst_illop` is high in the following cycle. With stop-enable = 1, `rst_illop` stays low.
- R9: After a timeout the counter restarts from zero, so `rst_wdog` falls after one cycle and the next pulse comes T edges later unless the watchdog is serviced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Options write enable |
| opt_wdata | input | 3 | Write data for option bits 7:5 (enable, period select, stop-enable) |
| cfg_rdata | output | 8 | Options register read value |
| svc_strobe | input | 1 | Watchdog service pulse |
| stop_try | input | 1 | Processor is attempting to enter stop mode |
| rst_wdog | output | 1 | Watchdog timeout reset request, one-cycle pulse |
| rst_illop | output | 1 | Illegal stop-attempt reset request |

## Verification
The bench uses 8-cycle and 64-cycle periods. It services the watchdog at every count position of the long period, including the terminal one. A design that let the timeout win over a same-edge service, or that counted from the wrong edge, would pulse early, late, or while being serviced.

It applies all eight option values as the first write, then writes their complement. A lock keyed to the written value, or one that missed some bits, would let the second write through. The test also shortens the period while the count is already past the short limit. An equality-only compare would then miss the terminal value and wait out the full counter range instead of firing at once.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  typedef struct packed {
    logic run;
    logic long_sel;
    logic stop_ok;
  } wdg_opts_t;

  localparam logic [4:0] WDG_FILL     = 5'b10011;
  localparam wdg_opts_t  WDG_OPTS_RST = '{run: 1'b1, long_sel: 1'b1, stop_ok: 1'b0};
endpackage

// File: rtl/wdg_opt_reg.sv
module wdg_opt_reg
  import wdg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_bits,
  output wdg_opts_t  opts,
  output logic       locked,
  output logic [7:0] rd_val
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opts   <= WDG_OPTS_RST;
      locked <= 1'b0;
    end else if (wr_en && !locked) begin
      opts   <= wdg_opts_t'(wr_bits);
      locked <= 1'b1;
    end
  end

  assign rd_val = {opts, WDG_FILL};
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int SHORT_EXP = 13,
  parameter int LONG_EXP  = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic long_sel,
  input  logic svc,
  output logic tmo_pulse
);
  localparam int CW = LONG_EXP;
  localparam logic [CW-1:0] LONG_LAST  = {CW{1'b1}};
  localparam logic [CW-1:0] SHORT_LAST = LONG_LAST >> (LONG_EXP - SHORT_EXP);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  logic          hit;

  // Compare with >= so that a period shortened mid-count still fires.
  assign last = long_sel ? LONG_LAST : SHORT_LAST;
  assign hit  = (cnt >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      tmo_pulse <= 1'b0;
    end else begin
      tmo_pulse <= 1'b0;
      if (!run || svc) begin
        cnt <= '0;
      end else if (hit) begin
        cnt       <= '0;
        tmo_pulse <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdg_stop_guard.sv
module wdg_stop_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_try,
  input  logic stop_ok,
  output logic illop_req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) illop_req <= 1'b0;
    else        illop_req <= stop_try && !stop_ok;
  end
endmodule

// File: rtl/sys_watchdog.sv
module sys_watchdog
  import wdg_pkg::*;
#(
  parameter int SHORT_EXP = 13,
  parameter int LONG_EXP  = 18
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [2:0] opt_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       svc_strobe,
  input  logic       stop_try,
  output logic       rst_wdog,
  output logic       rst_illop
);
  wdg_opts_t opts;
  logic      opt_locked;

  wdg_opt_reg u_opts (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_bits (opt_wdata),
    .opts    (opts),
    .locked  (opt_locked),
    .rd_val  (cfg_rdata)
  );

  wdg_counter #(.SHORT_EXP(SHORT_EXP), .LONG_EXP(LONG_EXP)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (opts.run),
    .long_sel  (opts.long_sel),
    .svc       (svc_strobe),
    .tmo_pulse (rst_wdog)
  );

  wdg_stop_guard u_stop (
    .clk       (clk),
    .rst_n     (rst_n),
    .stop_try  (stop_try),
    .stop_ok   (opts.stop_ok),
    .illop_req (rst_illop)
  );
endmodule

// File: rtl/wdg_chk.sv
module wdg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic       svc_strobe,
  input logic       stop_try,
  input logic [7:0] cfg_rdata,
  input logic       rst_wdog,
  input logic       rst_illop,
  input logic       locked
);
  // R2
  fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[4:0] == 5'b10011);

  // R3
  write_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> locked);

  // R3
  locked_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(cfg_rdata[7:5]));

  // R5
  svc_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_strobe |=> !rst_wdog);

  // R6
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[7] |=> !rst_wdog);

  // R8
  illop_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_try && !cfg_rdata[5]) |=> rst_illop);

  // R8
  stop_allowed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[5] |=> !rst_illop);

  // R9
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_wdog |=> !rst_wdog);
endmodule

bind sys_watchdog wdg_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .svc_strobe (svc_strobe),
  .stop_try   (stop_try),
  .cfg_rdata  (cfg_rdata),
  .rst_wdog   (rst_wdog),
  .rst_illop  (rst_illop),
  .locked     (opt_locked)
);

// File: tb/sim_sys_watchdog.sv
`timescale 1ns/1ps
module sim_sys_watchdog;
  localparam int SE = 3;
  localparam int LE = 6;
  localparam int TS = 1 << SE;
  localparam int TL = 1 << LE;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [2:0] opt_wdata;
  logic [7:0] cfg_rdata;
  logic       svc_strobe;
  logic       stop_try;
  logic       rst_wdog;
  logic       rst_illop;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  sys_watchdog #(.SHORT_EXP(SE), .LONG_EXP(LE)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .opt_wdata(opt_wdata),
    .cfg_rdata(cfg_rdata), .svc_strobe(svc_strobe), .stop_try(stop_try),
    .rst_wdog(rst_wdog), .rst_illop(rst_illop)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_we = 1'b0; opt_wdata = '0; svc_strobe = 1'b0; stop_try = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Pulse expected after exactly T edges from now.
  task automatic run_expect(input int t, input string req);
    bit early = 1'b0;
    for (int i = 1; i < t; i++) begin
      tick();
      if (rst_wdog) early = 1'b1;
    end
    check(!early, {req, " early pulse"}, early, 0);
    tick();
    check(rst_wdog == 1'b1, {req, " pulse at terminal"}, rst_wdog, 1);
  endtask

  task automatic quiet(input int n, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      tick();
      if (rst_wdog) seen = 1'b1;
    end
    check(!seen, req, seen, 0);
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    // R1 reset state
    rst_n = 1'b0; cfg_we = 1'b0; opt_wdata = '0; svc_strobe = 1'b0; stop_try = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(cfg_rdata == 8'hD3, "R1 rdata in reset", cfg_rdata, 8'hD3);
    check(!rst_wdog && !rst_illop, "R1 outputs in reset", {rst_wdog, rst_illop}, 0);
    rst_n = 1'b1;
    tick();
    check(cfg_rdata == 8'hD3, "R1 rdata after release", cfg_rdata, 8'hD3);

    // R4 / R9 long period from reset, twice in a row
    do_reset();
    run_expect(TL, "R4 long from reset");
    tick();
    check(!rst_wdog, "R9 pulse one cycle", rst_wdog, 0);
    run_expect(TL - 1, "R9 second period");

    // R5 service at every count position, including terminal
    for (int m = 0; m < TL; m++) begin
      do_reset();
      quiet(m, "R5 before service");
      svc_strobe = 1'b1;
      tick();
      svc_strobe = 1'b0;
      check(!rst_wdog, "R5 no pulse on service edge", rst_wdog, 0);
      run_expect(TL, "R5 period after service");
    end

    // R3 R4 R6 R8 all first-write values
    for (int v = 0; v < 8; v++) begin
      logic [2:0] vb;
      vb = 3'(v);
      do_reset();
      cfg_we = 1'b1; opt_wdata = vb; svc_strobe = 1'b1;
      tick();
      cfg_we = 1'b0; svc_strobe = 1'b0;
      check(cfg_rdata == {vb, 5'b10011}, "R3 first write", cfg_rdata, {vb, 5'b10011});
      check(cfg_rdata[4:0] == 5'b10011, "R2 fixed bits", cfg_rdata[4:0], 5'b10011);
      cfg_we = 1'b1; opt_wdata = ~vb;
      tick();
      cfg_we = 1'b0;
      check(cfg_rdata == {vb, 5'b10011}, "R3 second write ignored", cfg_rdata, {vb, 5'b10011});
      svc_strobe = 1'b1;
      tick();
      svc_strobe = 1'b0;
      if (vb[2]) begin
        run_expect(vb[1] ? TL : TS, "R4 period by select");
        run_expect(vb[1] ? TL : TS, "R9 repeat period");
      end else begin
        quiet(TL + 5, "R6 disabled no pulse");
      end
      stop_try = 1'b1;
      tick();
      check(rst_illop == !vb[0], "R8 stop attempt", rst_illop, !vb[0]);
      tick();
      stop_try = 1'b0;
      check(rst_illop == !vb[0], "R8 held attempt", rst_illop, !vb[0]);
      tick();
      check(!rst_illop, "R8 after release", rst_illop, 0);
    end

    // R7 shorten period while count already beyond short limit
    do_reset();
    quiet(20, "R7 pre-count");
    cfg_we = 1'b1; opt_wdata = 3'b100;
    tick();
    cfg_we = 1'b0;
    check(!rst_wdog, "R7 no pulse on write edge", rst_wdog, 0);
    tick();
    check(rst_wdog == 1'b1, "R7 immediate pulse", rst_wdog, 1);
    run_expect(TS, "R7 short period after");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule